// File: doc/BRIEF.md
# Repeater Port Status Display Scanner

This block drives a multiplexed LED status display for a thirteen-port repeater. Per-port status arrives as parallel vectors: link, collision, reception, partition and inverted receive polarity. A flag per port says whether that port runs on its internal twisted-pair transceiver. Three repeater-wide summary flags also arrive: any-port collision, any-port reception and any-port jabber. The block walks through the display slots in a fixed order. For each slot it puts a 3-bit slot address and five flag bits on one shared 8-bit bus. It then pulses one of two bank strobes, so that an external bank of addressable latches captures the bits.

Two latch banks share the bus. The lower bank gives slot 0 to the repeater-wide summary and slots 1 to 7 to ports 1 to 7. Port 1 is the attachment-unit port. The upper bank gives slots 0 to 5 to ports 8 to 13. Depending on the `SKIP_UNUSED` parameter, upper slots 6 and 7 are either strobed with zero data or left out of the scan. A central state machine sequences each slot through five states. LOAD samples the inputs. SETUP presents the bus. STROBE pulses the strobe. HOLD keeps the bus after the strobe. GAP stretches the slot by a programmable number of cycles.

The transitions are LOAD to SETUP, SETUP to STROBE, and STROBE to HOLD. From HOLD the machine goes to LOAD when the gap is zero, and to GAP otherwise. GAP goes to LOAD once the gap count is reached. The slot pointer advances on every arc into LOAD except the one out of reset.

Top module: `status_scan_top`

## Requirements
- R1: The bus `disp_bus[7:5]` carries the slot address. `disp_bus[4:0]` carries the flags: bit 0 link, bit 1 collision, bit 2 reception, bit 3 partition or jabber, bit 4 inverted polarity.
- R2: Lower-bank slots 1 to 7 carry the flags of ports 1 to 7 (vector bits 0 to 6) and are latched by `strb[0]`.
- R3: Lower-bank slot 0 carries `col_any` on bit 1, `rcv_any` on bit 2 and `jab_any` on bit 3. Bits 0 and 4 are zero.
- R4: Upper-bank slots 0 to 5 carry the flags of ports 8 to 13 (vector bits 7 to 12) and are latched by `strb[1]`.
- R5: The polarity bit is the port's `bad_pol` ANDed with its `int_xcvr`. It is always 0 for port 1.
- R6: With `SKIP_UNUSED`=0, upper slots 6 and 7 are strobed with all-zero flags. With `SKIP_UNUSED`=1 they are never visited.
- R7: The scan order is lower slots 0 to 7, then the upper slots in ascending order, then back to lower slot 0.
- R8: A strobe lasts exactly one cycle and at most one strobe is high at a time. The bus is stable in the cycle before the strobe, during it and in the cycle after it.
- R9: Consecutive strobes are 4 + `slot_gap` cycles apart.
- R10: The flags of a slot are sampled in its LOAD cycle. Input changes after that cycle do not alter the bus for that slot.
- R11: Synchronous reset drives both strobes low and the bus to zero. After release, the first strobe is lower slot 0, two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_gap | input | 8 | Extra idle cycles per slot |
| link | input | 13 | Link good per port (bit 0 = port 1) |
| col | input | 13 | Collision per port |
| rcv | input | 13 | Reception per port |
| part | input | 13 | Partitioned per port |
| bad_pol | input | 13 | Inverted receive polarity per port |
| int_xcvr | input | 13 | Port uses internal transceiver |
| col_any | input | 1 | Repeater-wide collision summary |
| rcv_any | input | 1 | Repeater-wide reception summary |
| jab_any | input | 1 | Repeater-wide jabber summary |
| disp_bus | output | 8 | Slot address and flag bits |
| strb | output | 2 | Bank strobes, bit 0 lower, bit 1 upper |

## Verification
The gap-counter assertion takes for granted that `slot_gap` changes only in the HOLD cycle, so that no count already under way is overtaken by a smaller limit. The stimulus respects this by moving the gap only in the negative half of a HOLD cycle. The flag inputs follow the same rule: the bench swaps in a new pattern only after the last slot of a full scan. To exercise R10 it drives deliberately inverted values in the strobe cycle and restores them in the HOLD cycle. Both of those moments fall after the slot's LOAD sample and before the next one.

// File: rtl/status_scan_pkg.sv
package status_scan_pkg;

    localparam int SLOT_W = 3;
    localparam int FLAG_W = 5;
    localparam int BUS_W  = SLOT_W + FLAG_W;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_GAP
    } scan_state_e;

    typedef struct packed {
        logic pol;
        logic part;
        logic rcv;
        logic col;
        logic link;
    } flags_t;

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import status_scan_pkg::*;
#(
    parameter int GAP_W       = 8,
    parameter int HI_PORTS    = 6,
    parameter bit SKIP_UNUSED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GAP_W-1:0]  slot_gap,
    output logic              bank_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              load_o,
    output logic              strobe_o
);
    localparam logic [SLOT_W-1:0] LO_LAST = '1;
    localparam logic [SLOT_W-1:0] HI_LAST =
        SKIP_UNUSED ? SLOT_W'(HI_PORTS - 1) : '1;

    scan_state_e       state_q, state_d;
    logic [GAP_W-1:0]  cnt_q;
    logic              bank_q;
    logic [SLOT_W-1:0] slot_q;
    logic              gap_done;
    logic              advance;

    assign gap_done = ({1'b0, cnt_q} + 1'b1) >= {1'b0, slot_gap};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:   state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: state_d = ST_HOLD;
            ST_HOLD:   state_d = (slot_gap == '0) ? ST_LOAD : ST_GAP;
            ST_GAP:    state_d = gap_done ? ST_LOAD : ST_GAP;
            default:   state_d = ST_LOAD;
        endcase
    end

    assign advance = (state_q != ST_LOAD) && (state_d == ST_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
            bank_q  <= 1'b0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_GAP) ? cnt_q + 1'b1 : '0;
            if (advance) begin
                if (!bank_q && slot_q == LO_LAST) begin
                    bank_q <= 1'b1;
                    slot_q <= '0;
                end else if (bank_q && slot_q == HI_LAST) begin
                    bank_q <= 1'b0;
                    slot_q <= '0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        load_o   = (state_q == ST_LOAD);
        strobe_o = (state_q == ST_STROBE);
        bank_o   = bank_q;
        slot_o   = slot_q;
    end

    // R7: a bank change always lands on slot 0
    a_r7_bank_turn_at_zero: assert property (@(posedge clk) disable iff (rst)
        !$stable(bank_q) |-> slot_q == '0);

    // R6: with skipping on, the upper bank never points past its last port
    a_r6_skip_range: assert property (@(posedge clk) disable iff (rst)
        (SKIP_UNUSED && bank_q) |-> slot_q < SLOT_W'(HI_PORTS));

    // R9: the gap counter stays below the programmed gap
    a_r9_gap_bound: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_GAP |-> cnt_q < slot_gap);

endmodule

// File: rtl/slot_flag_mux.sv
module slot_flag_mux
    import status_scan_pkg::*;
#(
    parameter int NPORT    = 13,
    parameter int LO_PORTS = 7,
    parameter int AUI_PORT = 0
) (
    input  logic              bank_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [NPORT-1:0]  link,
    input  logic [NPORT-1:0]  col,
    input  logic [NPORT-1:0]  rcv,
    input  logic [NPORT-1:0]  part,
    input  logic [NPORT-1:0]  bad_pol,
    input  logic [NPORT-1:0]  int_xcvr,
    input  logic              col_any,
    input  logic              rcv_any,
    input  logic              jab_any,
    output flags_t            flags_o
);
    localparam int HI_PORTS = NPORT - LO_PORTS;
    localparam int IDX_W    = $clog2(NPORT + 1) + 1;

    flags_t            pflags [NPORT];
    logic [IDX_W-1:0]  idx;
    logic              in_range;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        localparam bit POL_OK = (i != AUI_PORT);
        assign pflags[i].pol  = bad_pol[i] & int_xcvr[i] & POL_OK;
        assign pflags[i].part = part[i];
        assign pflags[i].rcv  = rcv[i];
        assign pflags[i].col  = col[i];
        assign pflags[i].link = link[i];
    end

    always_comb begin
        if (!bank_i) begin
            idx      = IDX_W'(slot_i) - 1'b1;
            in_range = (slot_i != '0);
        end else begin
            idx      = IDX_W'(LO_PORTS) + IDX_W'(slot_i);
            in_range = (IDX_W'(slot_i) < IDX_W'(HI_PORTS));
        end
    end

    always_comb begin
        flags_o = '0;
        if (!bank_i && slot_i == '0) begin
            flags_o.col  = col_any;
            flags_o.rcv  = rcv_any;
            flags_o.part = jab_any;
        end else if (in_range && idx < IDX_W'(NPORT)) begin
            flags_o = pflags[idx];
        end
    end

endmodule

// File: rtl/status_scan_top.sv
module status_scan_top
    import status_scan_pkg::*;
#(
    parameter int NPORT       = 13,
    parameter int LO_PORTS    = 7,
    parameter int AUI_PORT    = 0,
    parameter int GAP_W       = 8,
    parameter bit SKIP_UNUSED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GAP_W-1:0]  slot_gap,
    input  logic [NPORT-1:0]  link,
    input  logic [NPORT-1:0]  col,
    input  logic [NPORT-1:0]  rcv,
    input  logic [NPORT-1:0]  part,
    input  logic [NPORT-1:0]  bad_pol,
    input  logic [NPORT-1:0]  int_xcvr,
    input  logic              col_any,
    input  logic              rcv_any,
    input  logic              jab_any,
    output logic [BUS_W-1:0]  disp_bus,
    output logic [1:0]        strb
);
    localparam int HI_PORTS = NPORT - LO_PORTS;

    logic              bank;
    logic [SLOT_W-1:0] slot;
    logic              load;
    logic              strobe_on;
    flags_t            flags;
    logic              bus_bank_q;
    logic [BUS_W-1:0]  bus_q;

    scan_sequencer #(
        .GAP_W      (GAP_W),
        .HI_PORTS   (HI_PORTS),
        .SKIP_UNUSED(SKIP_UNUSED)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .slot_gap(slot_gap),
        .bank_o  (bank),
        .slot_o  (slot),
        .load_o  (load),
        .strobe_o(strobe_on)
    );

    slot_flag_mux #(
        .NPORT   (NPORT),
        .LO_PORTS(LO_PORTS),
        .AUI_PORT(AUI_PORT)
    ) u_mux (
        .bank_i  (bank),
        .slot_i  (slot),
        .link    (link),
        .col     (col),
        .rcv     (rcv),
        .part    (part),
        .bad_pol (bad_pol),
        .int_xcvr(int_xcvr),
        .col_any (col_any),
        .rcv_any (rcv_any),
        .jab_any (jab_any),
        .flags_o (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q      <= '0;
            bus_bank_q <= 1'b0;
        end else if (load) begin
            bus_q      <= {slot, flags};
            bus_bank_q <= bank;
        end
    end

    always_comb begin
        disp_bus = bus_q;
        strb     = '0;
        if (strobe_on) strb[bus_bank_q] = 1'b1;
    end

    // R8: never both strobes together
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strb));

    // R8: bus already settled in the cycle before a strobe
    a_r8_setup: assert property (@(posedge clk) disable iff (rst)
        strb != 2'b00 |-> $stable(disp_bus));

    // R8: single-cycle strobe and bus held one cycle after
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        strb != 2'b00 |=> (strb == 2'b00) && $stable(disp_bus));

    // R6: unused upper slots carry no flags
    a_r6_zero_unused: assert property (@(posedge clk) disable iff (rst)
        (strb[1] && disp_bus[7:5] >= SLOT_W'(HI_PORTS)) |-> disp_bus[4:0] == '0);

    // R3: the summary slot has no link or polarity bit
    a_r3_summary_slot: assert property (@(posedge clk) disable iff (rst)
        (strb[0] && disp_bus[7:5] == '0) |-> (disp_bus[4] == 1'b0 && disp_bus[0] == 1'b0));

endmodule

// File: tb/tb_status_scan_top.sv
module tb_status_scan_top;
    localparam int NP = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    slot_gap = '0;
    logic [NP-1:0] link = '0, col = '0, rcv = '0, part = '0, bad_pol = '0, int_xcvr = '0;
    logic          col_any = 1'b0, rcv_any = 1'b0, jab_any = 1'b0;
    logic [7:0]    disp_bus, sk_bus;
    logic [1:0]    strb, sk_strb;

    logic [NP-1:0] c_link, c_col, c_rcv, c_part, c_pol, c_xcvr;
    logic          c_cany, c_rany, c_jany;

    int n_chk = 0, n_bad = 0;
    longint cyc = 0, last_strb = -1;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    status_scan_top dut (
        .clk(clk), .rst(rst), .slot_gap(slot_gap), .link(link), .col(col), .rcv(rcv),
        .part(part), .bad_pol(bad_pol), .int_xcvr(int_xcvr), .col_any(col_any),
        .rcv_any(rcv_any), .jab_any(jab_any), .disp_bus(disp_bus), .strb(strb));

    status_scan_top #(.SKIP_UNUSED(1'b1)) dut_skip (
        .clk(clk), .rst(rst), .slot_gap(slot_gap), .link(link), .col(col), .rcv(rcv),
        .part(part), .bad_pol(bad_pol), .int_xcvr(int_xcvr), .col_any(col_any),
        .rcv_any(rcv_any), .jab_any(jab_any), .disp_bus(sk_bus), .strb(sk_strb));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_flags(input bit b, input int s);
        int p;
        if (!b && s == 0) return {1'b0, c_jany, c_rany, c_cany, 1'b0};
        if (b && s >= 6) return 5'b0;
        p = b ? 7 + s : s - 1;
        return {c_pol[p] & c_xcvr[p] & (p != 0), c_part[p], c_rcv[p], c_col[p], c_link[p]};
    endfunction

    task automatic drive(input bit inv);
        link = inv ? ~c_link : c_link;  col = inv ? ~c_col : c_col;
        rcv = inv ? ~c_rcv : c_rcv;     part = inv ? ~c_part : c_part;
        bad_pol = inv ? ~c_pol : c_pol; int_xcvr = inv ? ~c_xcvr : c_xcvr;
        col_any = inv ^ c_cany; rcv_any = inv ^ c_rany; jab_any = inv ^ c_jany;
    endtask

    task automatic set_pattern(input int p);
        c_link = NP'(13'h1 << (p % 13)) ^ ((p >= 13) ? '1 : '0);
        c_col  = NP'(p * 32'h0b5);
        c_rcv  = ~NP'(13'h1 << ((p + 5) % 13));
        c_part = NP'(p * 32'h137) ^ 13'h0a5a;
        c_pol  = NP'(13'h1fff >> (p % 7));
        c_xcvr = (p % 2 == 1) ? 13'h1fff : (13'h0f0f ^ NP'(p));
        c_cany = p[0]; c_rany = p[1]; c_jany = p[2];
        slot_gap = 8'(p % 4);
        drive(1'b0);
    endtask

    task automatic check_slot(input bit b, input int s);
        logic [7:0] prev, seen;
        int waited = 0;
        string req;
        prev = disp_bus;
        forever begin
            @(negedge clk);
            if (strb != 2'b00) break;
            prev = disp_bus;
            waited++;
            if (waited > 600) begin
                chk("R7 strobe timeout", 32'(strb), b ? 2 : 1);
                return;
            end
        end
        req = (!b && s == 0) ? "R3 summary" : (b && s >= 6) ? "R6 unused" :
              b ? "R4 upper/R5" : "R2 lower/R5";
        chk("R7 bank strobe", 32'(strb), b ? 2 : 1);
        chk({req, " R1 bus"}, 32'(disp_bus), {s[2:0], exp_flags(b, s)});
        chk("R8 setup", 32'(prev), 32'(disp_bus));
        if (last_strb >= 0) chk("R9 period", 32'(cyc - last_strb), 32'(4 + slot_gap));
        last_strb = cyc;
        seen = disp_bus;
        drive(1'b1);
        @(negedge clk);
        chk("R8 one-cycle strobe", 32'(strb), 0);
        chk("R10 snapshot hold", 32'(disp_bus), 32'(seen));
        drive(1'b0);
    endtask

    int sk_b = 0, sk_s = 0;
    always @(negedge clk) begin
        if (rst) begin
            sk_b = 0; sk_s = 0;
        end else if (sk_strb != 2'b00 && !done) begin
            chk("R6 skip bank", 32'(sk_strb), sk_b ? 2 : 1);
            chk("R6 skip addr", 32'(sk_bus[7:5]), 32'(sk_s));
            if (!sk_b && sk_s == 7) begin sk_b = 1; sk_s = 0; end
            else if (sk_b && sk_s == 5) begin sk_b = 0; sk_s = 0; end
            else sk_s++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        set_pattern(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset strobe", 32'(strb), 0);
        chk("R11 reset bus", 32'(disp_bus), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 no strobe first cycle", 32'(strb), 0);
        @(negedge clk);
        chk("R11 first strobe at lower 0", 32'(strb), 1);
        chk("R11 first slot addr", 32'(disp_bus[7:5]), 0);
        last_strb = -1;
        // the first strobe is already visible; handle it like a slot check
        chk("R3 summary first slot", 32'(disp_bus), {3'd0, exp_flags(0, 0)});
        last_strb = cyc;
        @(negedge clk);
        for (int s = 1; s < 8; s++) check_slot(0, s);
        for (int s = 0; s < 8; s++) check_slot(1, s);
        for (int p = 1; p < 20; p++) begin
            set_pattern(p);
            for (int s = 0; s < 8; s++) check_slot(0, s);
            for (int s = 0; s < 8; s++) check_slot(1, s);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule